// File: doc/BRIEF.md
# Audio Capture Ring Buffer with Level and Overrun Interrupts

The block takes audio sample words from a receiver front end and stores them in an on-chip ring buffer. A write pointer moves forward each time a sample is stored while capture is on. A read pointer moves forward each time the host drains a word through a data register. Both pointers are visible to the host as word positions. A status register holds three sticky event bits: fill level, overrun and an external receiver event. An interrupt line combines these bits with per-source enables.

Samples arrive MSB-aligned in a 24-bit word. They are stored right-justified at one of four widths. A test mode replaces live samples with a constant pattern or a pseudo-random stream, which lets software check the capture path without a live source. The ring holds at most DEPTH-1 unread words. A sample that arrives when the ring is at that limit is dropped and flagged as an overrun.

Top module: `cap_ring`

## Requirements
- R1: After rst_n is held low for a clock edge, both pointers read 0, the status register reads 0, the control and enable registers read 0, and irq is 0.
- R2: While the record bit (control register at address 3, bit 0) is 0, a valid sample does not move the write pointer.
- R3: While recording, each accepted sample is stored at the write-pointer position, and the pointer (address 1) then advances by one modulo DEPTH (1024 by default). It wraps from DEPTH-1 to 0. The read pointer is reported at address 2.
- R4: A read of address 0 returns the oldest unread word and advances the read pointer by one. When the ring is empty, the read returns 0 and the read pointer does not move.
- R5: The stored word is the incoming 24-bit sample shifted right by 24 minus the width, with the width chosen by control bits 3:2 (00 = 16, 01 = 18, 10 = 20, 11 = 24).
- R6: Enable register (address 5) bits 1:0 pick the level threshold: 01 = DEPTH/8, 10 = DEPTH/4, 11 = DEPTH/2. Status bit 0 sets when the fill level (write minus read, modulo DEPTH) is at or above the threshold. Code 00 never sets it.
- R7: When a sample arrives while recording and the fill level is DEPTH-1, the sample is dropped, the write pointer holds, and status bit 1 sets.
- R8: A pulse on rx_evt sets status bit 2.
- R9: A read of the status register (address 4) returns the bits and clears them. A bit set by an event in the same cycle stays set.
- R10: irq is the OR of status bit 0 gated by a non-zero level code, status bit 1 gated by enable bit 2, and status bit 2 gated by enable bit 3.
- R11: Writing control bit 1 as 1 clears both pointers and the status register and reseeds the pseudo-random source. The other control bits of that write are stored, and bit 1 always reads back 0.
- R12: With control bit 4 set and bit 5 clear, every accepted sample is stored as 0x55, whatever the format.
- R13: With control bits 4 and 5 set, the stored words follow a 16-bit LFSR for x^16+x^14+x^13+x^11+1. The LFSR shifts right and feeds bit0^bit2^bit3^bit5 into bit 15. It starts at 0xACE1 after reset and steps once per accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Incoming sample strobe |
| smp_data | input | 24 | Incoming sample, MSB-aligned |
| rx_evt | input | 1 | External receiver event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle that the write pointer holds when recording is off or the ring is at its limit. They also check that an empty drain leaves the read pointer unchanged, that a status read with no new event leaves the status at zero, and that a receiver pulse always lands in the status. The soft clear and the LFSR are checked the same way. Only the bench scenarios can show that stored data come back in order with the correct justification and test patterns. The bench also covers exactly where the level threshold trips for each code, the pointer wrap after an overrun is relieved, and how the interrupt follows each enable.

// File: rtl/cap_ring_pkg.sv
// Shared types and constants for the capture ring buffer.
// Assumes the register bus is at least 16 bits wide.
package cap_ring_pkg;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_WPTR = 3'd1,
        A_RPTR = 3'd2,
        A_CTRL = 3'd3,
        A_STAT = 3'd4,
        A_IEN  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       pat_sel;
        logic       test_en;
        logic [1:0] fmt;
        logic       record;
    } ctrl_t;

    typedef struct packed {
        logic       rx_en;
        logic       ovr_en;
        logic [1:0] lvl_sel;
    } ien_t;

    localparam int STAT_LVL = 0;
    localparam int STAT_OVR = 1;
    localparam int STAT_RX  = 2;
    localparam int STAT_W   = 3;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    localparam logic [15:0] FIXED_PAT = 16'h0055;

    // One right shift of the x^16+x^14+x^13+x^11+1 Fibonacci LFSR.
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

endpackage

// File: rtl/cap_ring_src.sv
// Sample source selector. Right-justifies live samples to the selected
// width, or substitutes a constant or LFSR test word.
// Assumes SMP_W >= 24 and that live samples arrive MSB-aligned.
module cap_ring_src
    import cap_ring_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SMP_W-1:0] smp_in,
    input  logic [1:0]       fmt,
    input  logic             test_en,
    input  logic             pat_sel,
    input  logic             advance,
    output logic [SMP_W-1:0] word
);

    localparam int SH16 = SMP_W - 16;
    localparam int SH18 = SMP_W - 18;
    localparam int SH20 = SMP_W - 20;
    localparam int SH24 = SMP_W - 24;

    logic [15:0]      lfsr_q;
    logic [SMP_W-1:0] live;

    // Right-justify the live sample according to the format code.
    always_comb begin
        case (fmt)
            2'b00:   live = smp_in >> SH16;
            2'b01:   live = smp_in >> SH18;
            2'b10:   live = smp_in >> SH20;
            default: live = smp_in >> SH24;
        endcase
    end

    // Pick between live data and the two test patterns.
    always_comb begin
        if (!test_en)     word = live;
        else if (pat_sel) word = SMP_W'(lfsr_q);
        else              word = SMP_W'(FIXED_PAT);
    end

    // Step the LFSR once per stored pseudo-random word; reseed on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                  lfsr_q <= LFSR_SEED;
        else if (advance && test_en && pat_sel) lfsr_q <= lfsr_step(lfsr_q);
    end

    // R13
    always @(posedge clk) begin
        if (rst_n) lfsr_nonzero_chk: assert (lfsr_q != 16'h0);
    end

endmodule

// File: rtl/cap_ring_buf.sv
// Ring storage with write and read pointers. A write is dropped when
// the ring already holds DEPTH-1 words. A drain of an empty ring returns
// zero. Read data is registered and valid the cycle after the pop.
module cap_ring_buf #(
    parameter int DEPTH_LOG2 = 10,
    parameter int SMP_W      = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_req,
    input  logic [SMP_W-1:0]      wr_data,
    input  logic                  pop_req,
    output logic [DEPTH_LOG2-1:0] wr_ptr,
    output logic [DEPTH_LOG2-1:0] rd_ptr,
    output logic [DEPTH_LOG2-1:0] fill,
    output logic                  wr_acc,
    output logic                  ovr_evt,
    output logic [SMP_W-1:0]      pop_data
);

    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2-1:0] FULL_LVL = DEPTH_LOG2'(DEPTH - 1);

    logic [SMP_W-1:0] mem [DEPTH];
    logic             full;
    logic             empty;
    logic             pop_acc;

    // Derive occupancy and accept decisions from current pointers.
    always_comb begin
        fill    = wr_ptr - rd_ptr;
        full    = (fill == FULL_LVL);
        empty   = (fill == '0);
        wr_acc  = wr_req && !full && !clr;
        ovr_evt = wr_req && full && !clr;
        pop_acc = pop_req && !empty && !clr;
    end

    // Store accepted samples.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_data;
    end

    // Advance the write pointer on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) wr_ptr <= '0;
        else if (wr_acc)   wr_ptr <= wr_ptr + 1'b1;
    end

    // Advance the read pointer and register the drained word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            pop_data <= '0;
        end else begin
            if (clr)          rd_ptr <= '0;
            else if (pop_acc) rd_ptr <= rd_ptr + 1'b1;
            if (pop_req)      pop_data <= empty ? '0 : mem[rd_ptr];
        end
    end

    // R2
    wr_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !clr) |=> $stable(wr_ptr));

    // R7
    wr_hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !clr) |=> $stable(wr_ptr));

    // R4
    rd_hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !clr) |=> $stable(rd_ptr));

endmodule

// File: rtl/cap_ring_irq.sv
// Sticky status bits for level, overrun and receiver events, cleared by
// a status read (a new event wins). Combines them with the enables into irq.
// Assumes DEPTH_LOG2 >= 3 so that every threshold is non-zero.
module cap_ring_irq
    import cap_ring_pkg::*;
#(
    parameter int DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [DEPTH_LOG2-1:0] fill,
    input  ien_t                  ien,
    input  logic                  ovr_evt,
    input  logic                  rx_evt,
    input  logic                  stat_rd,
    output logic [STAT_W-1:0]     stat,
    output logic                  irq
);

    logic [DEPTH_LOG2-1:0] thresh;
    logic                  lvl_hit;
    logic [STAT_W-1:0]     evt;
    logic [STAT_W-1:0]     en_mask;

    // Select the fill threshold from the level code.
    always_comb begin
        case (ien.lvl_sel)
            2'b01:   thresh = DEPTH_LOG2'(1) << (DEPTH_LOG2 - 3);
            2'b10:   thresh = DEPTH_LOG2'(1) << (DEPTH_LOG2 - 2);
            default: thresh = DEPTH_LOG2'(1) << (DEPTH_LOG2 - 1);
        endcase
        lvl_hit = (ien.lvl_sel != 2'b00) && (fill >= thresh);
    end

    // Collect this cycle's events and per-source enables.
    always_comb begin
        evt = '0;
        evt[STAT_LVL] = lvl_hit;
        evt[STAT_OVR] = ovr_evt;
        evt[STAT_RX]  = rx_evt;
        en_mask = '0;
        en_mask[STAT_LVL] = (ien.lvl_sel != 2'b00);
        en_mask[STAT_OVR] = ien.ovr_en;
        en_mask[STAT_RX]  = ien.rx_en;
    end

    // Hold events until read; a read clears, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) stat <= '0;
        else               stat <= (stat & ~{STAT_W{stat_rd}}) | evt;
    end

    assign irq = |(stat & en_mask);

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (evt == '0)) |=> (stat == '0));

    // R8
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !clr) |=> stat[STAT_RX]);

endmodule

// File: rtl/cap_ring.sv
// Capture ring buffer top. Holds the control and enable registers,
// decodes host accesses, and wires the source, ring and interrupt logic.
// Assumes REG_W >= SMP_W, REG_W >= DEPTH_LOG2 and a single-cycle strobe bus.
module cap_ring
    import cap_ring_pkg::*;
#(
    parameter int DEPTH_LOG2 = 10,
    parameter int SMP_W      = 24,
    parameter int REG_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             rx_evt,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);

    ctrl_t                 ctrl_q;
    ien_t                  ien_q;
    reg_addr_e             addr;
    logic                  clr;
    logic                  pop_req;
    logic                  stat_rd;
    logic [SMP_W-1:0]      src_word;
    logic [DEPTH_LOG2-1:0] wr_ptr;
    logic [DEPTH_LOG2-1:0] rd_ptr;
    logic [DEPTH_LOG2-1:0] fill;
    logic                  wr_acc;
    logic                  ovr_evt;
    logic [SMP_W-1:0]      pop_data;
    logic [STAT_W-1:0]     stat;
    logic [REG_W-1:0]      rdata_q;
    logic                  data_sel_q;
    logic                  unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:6];

    // Decode strobes for the register bus.
    always_comb begin
        addr    = reg_addr_e'(reg_addr);
        clr     = reg_wr && (addr == A_CTRL) && reg_wdata[1];
        pop_req = reg_rd && (addr == A_DATA);
        stat_rd = reg_rd && (addr == A_STAT);
    end

    // Hold host-written control and enable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (reg_wr) begin
            if (addr == A_CTRL)
                ctrl_q <= '{pat_sel: reg_wdata[5], test_en: reg_wdata[4],
                            fmt: reg_wdata[3:2], record: reg_wdata[0]};
            if (addr == A_IEN)
                ien_q  <= '{rx_en: reg_wdata[3], ovr_en: reg_wdata[2],
                            lvl_sel: reg_wdata[1:0]};
        end
    end

    // Register read data for all non-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            data_sel_q <= 1'b0;
        end else if (reg_rd) begin
            data_sel_q <= (addr == A_DATA);
            case (addr)
                A_WPTR:  rdata_q <= REG_W'(wr_ptr);
                A_RPTR:  rdata_q <= REG_W'(rd_ptr);
                A_CTRL:  rdata_q <= REG_W'({ctrl_q.pat_sel, ctrl_q.test_en,
                                            ctrl_q.fmt, 1'b0, ctrl_q.record});
                A_STAT:  rdata_q <= REG_W'(stat);
                A_IEN:   rdata_q <= REG_W'({ien_q.rx_en, ien_q.ovr_en, ien_q.lvl_sel});
                default: rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = data_sel_q ? REG_W'(pop_data) : rdata_q;

    cap_ring_src #(.SMP_W(SMP_W)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .smp_in  (smp_data),
        .fmt     (ctrl_q.fmt),
        .test_en (ctrl_q.test_en),
        .pat_sel (ctrl_q.pat_sel),
        .advance (wr_acc),
        .word    (src_word)
    );

    cap_ring_buf #(.DEPTH_LOG2(DEPTH_LOG2), .SMP_W(SMP_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_req   (smp_valid && ctrl_q.record),
        .wr_data  (src_word),
        .pop_req  (pop_req),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .fill     (fill),
        .wr_acc   (wr_acc),
        .ovr_evt  (ovr_evt),
        .pop_data (pop_data)
    );

    cap_ring_irq #(.DEPTH_LOG2(DEPTH_LOG2)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .fill    (fill),
        .ien     (ien_q),
        .ovr_evt (ovr_evt),
        .rx_evt  (rx_evt),
        .stat_rd (stat_rd),
        .stat    (stat),
        .irq     (irq)
    );

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_ptr == '0 && rd_ptr == '0 && stat == '0));

endmodule

// File: tb/cap_ring_bench.sv
module cap_ring_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        rx_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [23:0] m_mem [DEPTH];
    int          m_wp, m_rp;
    logic [15:0] m_lfsr;
    logic        m_rec, m_ten, m_psel;
    logic [1:0]  m_fmt;

    cap_ring u_cap_ring (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rx_evt(rx_evt), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] exp_just(input logic [23:0] d, input logic [1:0] f);
        int w;
        w = (f == 2'd0) ? 16 : (f == 2'd1) ? 18 : (f == 2'd2) ? 20 : 24;
        return d >> (24 - w);
    endfunction

    function automatic logic [15:0] exp_lfsr_next(input logic [15:0] s);
        logic fb;
        fb = s[0] ^ s[2] ^ s[3] ^ s[5];
        return {fb, s[15:1]};
    endfunction

    function automatic int m_fill();
        return (m_wp - m_rp) & (DEPTH - 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input logic rec, input logic rst, input logic [1:0] f,
                            input logic ten, input logic psel);
        wr(3'd3, {18'd0, psel, ten, f, rst, rec});
        if (rst) begin m_wp = 0; m_rp = 0; m_lfsr = 16'hACE1; end
        m_rec = rec; m_fmt = f; m_ten = ten; m_psel = psel;
    endtask

    task automatic push(input logic [23:0] d);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
        if (m_rec && m_fill() != DEPTH - 1) begin
            if (!m_ten)      m_mem[m_wp] = exp_just(d, m_fmt);
            else if (m_psel) m_mem[m_wp] = {8'd0, m_lfsr};
            else             m_mem[m_wp] = 24'h55;
            if (m_ten && m_psel) m_lfsr = exp_lfsr_next(m_lfsr);
            m_wp = (m_wp + 1) & (DEPTH - 1);
        end
    endtask

    task automatic pop_chk(input string tag);
        logic [23:0] v;
        logic [23:0] e;
        rd(3'd0, v);
        if (m_fill() == 0) e = '0;
        else begin e = m_mem[m_rp]; m_rp = (m_rp + 1) & (DEPTH - 1); end
        chk(tag, v, e);
    endtask

    task automatic ptr_chk(input string tag);
        logic [23:0] v;
        rd(3'd1, v); chk({tag, " wptr"}, v, m_wp);
        rd(3'd2, v); chk({tag, " rptr"}, v, m_rp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        void'($urandom(32'd20240607));
        m_wp = 0; m_rp = 0; m_lfsr = 16'hACE1;
        m_rec = 0; m_ten = 0; m_psel = 0; m_fmt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", irq, 0);
        ptr_chk("R1");
        rd(3'd4, v); chk("R1 stat", v, 0);
        rd(3'd3, v); chk("R1 ctrl", v, 0);
        rd(3'd5, v); chk("R1 ien", v, 0);

        // R2 record off
        for (int i = 0; i < 5; i++) push($urandom);
        rd(3'd1, v); chk("R2 wptr idle", v, 0);

        // R3 R4 R5 random capture and drain across formats
        set_ctrl(1, 0, 2'd0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) push($urandom);
            else if (op < 9) pop_chk("R4 R5 data");
            else set_ctrl(1, 0, 2'($urandom_range(0, 3)), 0, 0);
        end
        ptr_chk("R3");
        while (m_fill() != 0) pop_chk("R4 drain");
        pop_chk("R4 empty read");
        ptr_chk("R4 empty");

        // R5 directed: one known sample per format
        for (int f = 0; f < 4; f++) begin
            set_ctrl(1, 0, 2'(f), 0, 0);
            push(24'hF1E2D3);
            pop_chk("R5 format");
        end

        // R6 level threshold
        set_ctrl(1, 1, 2'd0, 0, 0);
        wr(3'd5, 24'h1);
        for (int i = 0; i < 127; i++) push($urandom);
        idle();
        rd(3'd4, v); chk("R6 below eighth", v[0], 0);
        push($urandom);
        idle();
        chk("R10 irq level", irq, 1);
        rd(3'd4, v); chk("R6 at eighth", v[0], 1);
        wr(3'd5, 24'h0);
        rd(3'd4, v); idle();
        rd(3'd4, v); chk("R6 code00 off", v[0], 0);
        wr(3'd5, 24'h2);
        rd(3'd4, v); idle();
        rd(3'd4, v); chk("R6 below quarter", v[0], 0);

        // R7 overrun and R3 wrap
        set_ctrl(1, 1, 2'd3, 0, 0);
        wr(3'd5, 24'h4);
        for (int i = 0; i < DEPTH - 1; i++) push($urandom);
        rd(3'd1, v); chk("R7 wptr at limit", v, DEPTH - 1);
        chk("R10 irq quiet", irq, 0);
        push(24'hABCDEF);
        rd(3'd1, v); chk("R7 wptr held", v, DEPTH - 1);
        chk("R10 irq overrun", irq, 1);
        rd(3'd4, v); chk("R7 stat", v, 24'h2);
        pop_chk("R7 data after drop");
        push(24'h123456);
        rd(3'd1, v); chk("R3 wrap", v, 0);

        // R8 R9 R10 receiver event
        set_ctrl(1, 1, 2'd0, 0, 0);
        wr(3'd5, 24'h0);
        rx_evt = 1'b1; idle(); rx_evt = 1'b0;
        idle();
        chk("R10 rx masked", irq, 0);
        wr(3'd5, 24'h8);
        chk("R10 rx enabled", irq, 1);
        rd(3'd4, v); chk("R8 stat rx", v, 24'h4);
        chk("R9 irq after read", irq, 0);
        rd(3'd4, v); chk("R9 cleared", v, 0);

        // R11 soft clear
        for (int i = 0; i < 3; i++) push($urandom);
        set_ctrl(1, 1, 2'd0, 0, 0);
        ptr_chk("R11");
        rd(3'd3, v); chk("R11 ctrl readback", v, 24'h1);

        // R12 constant pattern
        set_ctrl(1, 0, 2'd1, 1, 0);
        for (int i = 0; i < 3; i++) push($urandom);
        for (int i = 0; i < 3; i++) pop_chk("R12 fixed");

        // R13 LFSR pattern
        set_ctrl(1, 1, 2'd0, 1, 1);
        for (int i = 0; i < 5; i++) push($urandom);
        rd(3'd0, v); chk("R13 seed word", v, 24'h00ACE1);
        m_rp = 1;
        for (int i = 0; i < 4; i++) pop_chk("R13 sequence");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule